// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block drives a processor through the multi-cycle entry into an interrupt handler. Three kinds of source compete for it. The highest is a non-maskable request. Below that is a maskable request. The lowest is a pair of software traps: break and coprocessor. The sequencer advances one phase on each cycle strobe. It reports the current bus phase and the handler vector address to fetch, and it pulses a completion flag tagged with the source that was serviced.

A request of higher rank can arrive while a lower-ranked entry is already running. How it is handled depends on how far that entry has progressed:

- **Takeover.** If the status push has not yet completed, the new source replaces the vector about to be fetched. The original request is dropped and is never serviced.
- **Nesting.** If the status push has completed, the running entry is parked and the new request gets a full entry of its own. When that nested entry finishes, the parked entry resumes from its vector fetch. Only one parked entry is held at a time.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset, phase_o is 0 (idle) and done_o is 0.
- R2: An entry visits phases 1 through 7 in order: wait, wait, push return-high, push return-low, push status, vector-low, vector-high. The phase advances only on a clock with step_i high, and one phase per step. A step in phase 7 ends the entry.
- R3: While busy, vec_addr_o shows the vector of the current source: non-maskable 16'hFFEA, maskable 16'hFFEE, break 16'hFFE6, coprocessor 16'hFFE4.
- R4: When the block is idle and several requests are present at a step, the source chosen follows this rank: non-maskable, then maskable, then break, then coprocessor. Source codes are 0 non-maskable, 1 maskable, 2 break, 3 coprocessor.
- R5: A rising edge on nmi_i is latched and stays pending until an entry takes it. Holding nmi_i high produces exactly one entry.
- R6: irq_i is level-sensitive and has no effect while irq_mask_i is high.
- R7: A higher-ranked request seen at a step taken in phases 1 to 5 replaces the current source. The replaced source is lost, so only one done pulse occurs, tagged with the new source.
- R8: A higher-ranked request seen at a step taken in phase 6 or 7, with nothing parked, parks the current entry and restarts at phase 1 with the new source. After the nested entry completes, the parked entry resumes at phase 6.
- R9: done_o is high for exactly one clock after the step that ends an entry, and done_src_o gives the source of that entry.
- R10: At most one entry is parked. While one is parked, a higher-ranked request in phase 6 or 7 does not nest, and the vector fetch continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Cycle strobe; advances the sequence |
| nmi_i | input | 1 | Non-maskable request, edge-triggered |
| irq_i | input | 1 | Maskable request, level |
| irq_mask_i | input | 1 | Interrupt-disable flag for irq_i |
| brk_i | input | 1 | Break trap request |
| cop_i | input | 1 | Coprocessor trap request |
| phase_o | output | 3 | Current bus phase (0 idle, 1..7) |
| vec_addr_o | output | 16 | Vector address of current source |
| done_o | output | 1 | Entry completion pulse |
| done_src_o | output | 2 | Source of the completed entry |

## Verification
A corrupted source register shows up at once on vec_addr_o, and again later in done_src_o when the entry ends. A wrong phase counter, or a lost parked entry, breaks the 1-to-7 walk within one step. A missing resume appears as a done pulse that never arrives, about two steps after the nested entry completes. The bench runs a step-accurate model beside the block and compares phase, vector and completion outputs on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_WAIT0, PH_WAIT1, PH_PUSH_HI, PH_PUSH_LO, PH_PUSH_ST, PH_VEC_LO, PH_VEC_HI
  } phase_t;

  typedef enum logic [1:0] {SRC_NMI, SRC_IRQ, SRC_BRK, SRC_COP} src_t;

  // lower value = more urgent; traps share a rank
  function automatic logic [1:0] src_rank(src_t s);
    case (s)
      SRC_NMI: return 2'd0;
      SRC_IRQ: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/intr_req_arb.sv
module intr_req_arb
  import intr_entry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic irq_i,
  input  logic irq_mask_i,
  input  logic brk_i,
  input  logic cop_i,
  input  logic nmi_take_i,
  output logic req_v_o,
  output src_t req_src_o
);
  logic nmi_q, nmi_pend_q;
  logic nmi_edge;

  assign nmi_edge = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_q      <= nmi_i;
      nmi_pend_q <= (nmi_pend_q & ~nmi_take_i) | nmi_edge;
    end
  end

  always_comb begin
    req_v_o   = 1'b1;
    req_src_o = SRC_NMI;
    if (nmi_pend_q)              req_src_o = SRC_NMI;
    else if (irq_i & ~irq_mask_i) req_src_o = SRC_IRQ;
    else if (brk_i)              req_src_o = SRC_BRK;
    else if (cop_i)              req_src_o = SRC_COP;
    else                         req_v_o   = 1'b0;
  end

  a_r5_nmi_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !nmi_q) |=> nmi_pend_q);
  a_r5_nmi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && !nmi_take_i) |=> nmi_pend_q);
endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
  import intr_entry_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  input  logic   req_v_i,
  input  src_t   req_src_i,
  output logic   nmi_take_o,
  output phase_t phase_o,
  output src_t   src_o,
  output logic   done_o,
  output src_t   done_src_o
);
  phase_t phase_q, phase_d;
  src_t   src_q, src_d, pend_src_q, pend_src_d, done_src_q, done_src_d;
  logic   pend_v_q, pend_v_d, done_q, done_d;
  logic   higher, early;

  assign higher = req_v_i && (src_rank(req_src_i) < src_rank(src_q));
  assign early  = (phase_q != PH_VEC_LO) && (phase_q != PH_VEC_HI);

  always_comb begin
    phase_d    = phase_q;
    src_d      = src_q;
    pend_v_d   = pend_v_q;
    pend_src_d = pend_src_q;
    done_d     = 1'b0;
    done_src_d = done_src_q;
    nmi_take_o = 1'b0;
    if (step_i) begin
      if (phase_q == PH_IDLE) begin
        if (req_v_i) begin
          phase_d    = PH_WAIT0;
          src_d      = req_src_i;
          nmi_take_o = (req_src_i == SRC_NMI);
        end
      end else if (early) begin
        if (higher) begin               // vector replaced, old source dropped
          src_d      = req_src_i;
          nmi_take_o = (req_src_i == SRC_NMI);
        end
        phase_d = phase_t'(phase_q + 3'd1);
      end else if (higher && !pend_v_q) begin  // nest ahead of current entry
        pend_v_d   = 1'b1;
        pend_src_d = src_q;
        src_d      = req_src_i;
        phase_d    = PH_WAIT0;
        nmi_take_o = (req_src_i == SRC_NMI);
      end else if (phase_q == PH_VEC_LO) begin
        phase_d = PH_VEC_HI;
      end else begin
        done_d     = 1'b1;
        done_src_d = src_q;
        if (pend_v_q) begin
          pend_v_d = 1'b0;
          src_d    = pend_src_q;
          phase_d  = PH_VEC_LO;
        end else begin
          phase_d = PH_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      src_q      <= SRC_NMI;
      pend_v_q   <= 1'b0;
      pend_src_q <= SRC_NMI;
      done_q     <= 1'b0;
      done_src_q <= SRC_NMI;
    end else begin
      phase_q    <= phase_d;
      src_q      <= src_d;
      pend_v_q   <= pend_v_d;
      pend_src_q <= pend_src_d;
      done_q     <= done_d;
      done_src_q <= done_src_d;
    end
  end

  assign phase_o    = phase_q;
  assign src_o      = src_q;
  assign done_o     = done_q;
  assign done_src_o = done_src_q;

  a_r2_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q));
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r8_resume_at_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && phase_q == PH_VEC_HI && pend_v_q) |=> (phase_q == PH_VEC_LO));
  a_r10_no_second_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pend_v_q && phase_q == PH_VEC_LO) |=> (phase_q == PH_VEC_HI));
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_entry_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] VEC_NMI = 16'hFFEA,
  parameter logic [15:0] VEC_IRQ = 16'hFFEE,
  parameter logic [15:0] VEC_BRK = 16'hFFE6,
  parameter logic [15:0] VEC_COP = 16'hFFE4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              nmi_i,
  input  logic              irq_i,
  input  logic              irq_mask_i,
  input  logic              brk_i,
  input  logic              cop_i,
  output logic [2:0]        phase_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              done_o,
  output logic [1:0]        done_src_o
);
  logic   req_v, nmi_take;
  src_t   req_src, cur_src, done_src;
  phase_t phase;

  intr_req_arb u_arb (
    .clk_i, .rst_ni, .nmi_i, .irq_i, .irq_mask_i, .brk_i, .cop_i,
    .nmi_take_i(nmi_take), .req_v_o(req_v), .req_src_o(req_src)
  );

  intr_seq_fsm u_fsm (
    .clk_i, .rst_ni, .step_i, .req_v_i(req_v), .req_src_i(req_src),
    .nmi_take_o(nmi_take), .phase_o(phase), .src_o(cur_src),
    .done_o, .done_src_o(done_src)
  );

  always_comb begin
    case (cur_src)
      SRC_NMI: vec_addr_o = ADDR_W'(VEC_NMI);
      SRC_IRQ: vec_addr_o = ADDR_W'(VEC_IRQ);
      SRC_BRK: vec_addr_o = ADDR_W'(VEC_BRK);
      default: vec_addr_o = ADDR_W'(VEC_COP);
    endcase
  end

  assign phase_o    = phase;
  assign done_src_o = done_src;
endmodule

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic step_i = 1'b1, nmi_i = 1'b0, irq_i = 1'b0, irq_mask_i = 1'b0, brk_i = 1'b0, cop_i = 1'b0;
  logic [2:0]  phase_o;
  logic [15:0] vec_addr_o;
  logic        done_o;
  logic [1:0]  done_src_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  intr_entry_seq u_dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [15:0] vec_of(int s);
    case (s) 0: return 16'hFFEA; 1: return 16'hFFEE; 2: return 16'hFFE6; default: return 16'hFFE4; endcase
  endfunction
  function automatic int rank_of(int s);
    return (s >= 2) ? 2 : s;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  // step-accurate model built from the requirements
  int m_ph = 0, m_src = 0, m_pv = 0, m_ps = 0, m_np = 0, m_nq = 0, m_done = 0, m_ds = 0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_src = 0; m_pv = 0; m_ps = 0; m_np = 0; m_nq = 0; m_done = 0; m_ds = 0;
    end else begin
      int rv, rs, take, edge_n;
      edge_n = nmi_i && !m_nq;
      rv = 1; rs = 0; take = 0;
      if (m_np) rs = 0;
      else if (irq_i && !irq_mask_i) rs = 1;
      else if (brk_i) rs = 2;
      else if (cop_i) rs = 3;
      else rv = 0;
      m_done = 0;
      if (step_i) begin
        if (m_ph == 0) begin
          if (rv) begin m_ph = 1; m_src = rs; take = (rs == 0); end
        end else if (m_ph <= 5) begin
          if (rv && rank_of(rs) < rank_of(m_src)) begin m_src = rs; take = (rs == 0); end
          m_ph++;
        end else if (rv && rank_of(rs) < rank_of(m_src) && !m_pv) begin
          m_pv = 1; m_ps = m_src; m_src = rs; m_ph = 1; take = (rs == 0);
        end else if (m_ph == 6) m_ph = 7;
        else begin
          m_done = 1; m_ds = m_src;
          if (m_pv) begin m_pv = 0; m_src = m_ps; m_ph = 6; end else m_ph = 0;
        end
      end
      m_np = (m_np && !take) || edge_n;
      m_nq = nmi_i;
    end
  end

  always @(negedge clk_i) if (rst_ni && !finished) begin
    check("R2 phase vs model", phase_o, m_ph);
    check("R9 done vs model", done_o, m_done);
    if (m_done) check("R9 done_src vs model", done_src_o, m_ds);
    if (m_ph != 0) check("R3 vector vs model", vec_addr_o, vec_of(m_src));
  end

  initial begin
    while (!finished) begin
      @(posedge clk_i); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int dones;
    void'($urandom(32'd4711));
    @(negedge clk_i); @(negedge clk_i);
    check("R1 reset phase", phase_o, 0);
    check("R1 reset done", done_o, 0);
    rst_ni = 1'b1;
    tick();
    check("R1 idle after reset", phase_o, 0);

    // R6 / R2 / R3 / R9: plain maskable entry
    irq_i = 1; tick(); irq_i = 0;
    check("R6 irq start", phase_o, 1);
    check("R3 irq vector", vec_addr_o, 16'hFFEE);
    tick(5); check("R2 reach vec low", phase_o, 6);
    tick();  check("R2 reach vec high", phase_o, 7);
    tick();  check("R9 done high", done_o, 1);
    check("R9 done src irq", done_src_o, 1);
    check("R2 idle after end", phase_o, 0);
    tick();  check("R9 done one cycle", done_o, 0);

    // R2: hold without strobe
    brk_i = 1; tick(); brk_i = 0; step_i = 0;
    tick(3); check("R2 hold no step", phase_o, 1);
    check("R3 brk vector", vec_addr_o, 16'hFFE6);
    step_i = 1; tick(7);
    check("R9 done src brk", done_src_o, 2);

    // R6: masked level
    irq_i = 1; irq_mask_i = 1; tick(3);
    check("R6 masked irq ignored", phase_o, 0);
    irq_i = 0; irq_mask_i = 0;

    // R4 / R5: simultaneous, nmi held high
    nmi_i = 1; irq_i = 1; brk_i = 1; cop_i = 1; step_i = 0; tick();
    step_i = 1; tick();
    check("R4 nmi wins", vec_addr_o, 16'hFFEA);
    irq_i = 0; brk_i = 0; cop_i = 0;
    tick(7); check("R5 nmi done src", done_src_o, 0);
    tick(3); check("R5 held nmi single entry", phase_o, 0);
    nmi_i = 0; tick();

    // R4: irq over brk
    irq_i = 1; brk_i = 1; tick(); irq_i = 0; brk_i = 0;
    check("R4 irq over brk", vec_addr_o, 16'hFFEE);
    tick(7);

    // R7: takeover before cutoff
    brk_i = 1; tick(); brk_i = 0; tick();
    irq_i = 1; tick(); irq_i = 0;
    check("R7 takeover vector", vec_addr_o, 16'hFFEE);
    check("R7 sequence continues", phase_o, 3);
    dones = 0;
    for (int i = 0; i < 9; i++) begin
      tick();
      if (done_o) begin dones++; check("R7 done src new", done_src_o, 1); end
    end
    check("R7 old source lost", dones, 1);

    // R8: nesting after cutoff
    brk_i = 1; tick(); brk_i = 0; tick(5);
    nmi_i = 1; tick(); check("R8 vec high before nest", phase_o, 7);
    tick(); nmi_i = 0;
    check("R8 nested restart", phase_o, 1);
    check("R8 nested vector", vec_addr_o, 16'hFFEA);
    tick(7);
    check("R8 nested done src", done_src_o, 0);
    check("R8 resume phase", phase_o, 6);
    check("R8 resume vector", vec_addr_o, 16'hFFE6);
    tick(2); check("R8 resumed done src", done_src_o, 2);
    check("R8 resumed done", done_o, 1);

    // R10: one parked entry only
    cop_i = 1; tick(); cop_i = 0; tick(5);
    irq_i = 1; tick(); irq_i = 0;
    check("R10 first nest", vec_addr_o, 16'hFFEE);
    tick(5); nmi_i = 1; tick();
    check("R10 no second nest", phase_o, 7);
    tick();
    check("R10 irq done", done_src_o, 1);
    check("R10 cop resumed", vec_addr_o, 16'hFFE4);
    tick(); nmi_i = 0;
    check("R10 nmi nests after", vec_addr_o, 16'hFFEA);
    tick(7); check("R10 nmi done", done_src_o, 0);
    tick(2); check("R10 cop done", done_src_o, 3);

    // random traffic against model
    for (int i = 0; i < 4000; i++) begin
      step_i     = ($urandom_range(9) < 7);
      if ($urandom_range(15) == 0) nmi_i = ~nmi_i;
      irq_i      = ($urandom_range(7) == 0);
      irq_mask_i = ($urandom_range(3) == 0);
      brk_i      = ($urandom_range(11) == 0);
      cop_i      = ($urandom_range(13) == 0);
      tick();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule